// File: doc/BRIEF.md
# Iterative GCD Datapath

This block holds the two working registers of an iterative greatest-common-divisor engine and the arithmetic between them. A separate controller steers it cycle by cycle through select and enable inputs; the datapath itself has no state sequence of its own. It obeys whatever the controller asks for in each cycle: load fresh operands, exchange the two registers, or replace the first register with its difference from the second.

Two status flags go back to the controller. One says the first register is below the second, and the other says the second register is zero. Both are combinational functions of the current register contents, so the controller can choose the next step in the same cycle. A controller that swaps while the first register is smaller, subtracts while the second is nonzero, and stops otherwise leaves the GCD in the first register. That register is presented on the result output at all times.

Top module: `gcd_dp`

## Requirements
- R1: A synchronous active-low reset clears both working registers (X and Y) to zero. After reset, `result` is 0, `y_zero` is 1 and `x_lt_y` is 0.
- R2: With `x_sel`=0, `y_sel`=0 and both enables high, one clock edge loads X from `opnd_x` and Y from `opnd_y`.
- R3: With `x_sel`=1, `y_sel`=1 and both enables high, one clock edge exchanges the registers. X takes the old Y and Y takes the old X.
- R4: With `x_sel`=2, `x_en` high and `y_en` low, one clock edge writes X−Y (modulo 2^WIDTH) into X, and Y keeps its value.
- R5: A register whose enable is low keeps its value at the clock edge, whatever its select and data inputs are.
- R6: `x_sel`=3 with `x_en` high leaves X unchanged.
- R7: `x_lt_y` is 1 exactly when X is below Y, compared as unsigned numbers over the full WIDTH bits (default 16).
- R8: `y_zero` is 1 exactly when Y is zero. It follows the register in the same cycle, with no extra delay.
- R9: `result` always shows the current value of X.
- R10: If a controller loads operands, then swaps while `x_lt_y`=1, subtracts while `y_zero`=0, and stops otherwise, X ends at the GCD. When one operand is zero, X ends at the other operand. When both are zero, X ends at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| opnd_x | input | WIDTH | External operand for X |
| opnd_y | input | WIDTH | External operand for Y |
| x_sel | input | 2 | X source: 0 operand, 1 Y register, 2 difference, 3 hold |
| x_en | input | 1 | Write enable for X |
| y_sel | input | 1 | Y source: 0 operand, 1 X register |
| y_en | input | 1 | Write enable for Y |
| x_lt_y | output | 1 | X below Y (unsigned) |
| y_zero | output | 1 | Y equals zero |
| result | output | WIDTH | Current X value |

## Verification
The exchange is the one place where both registers are written in the same edge, and each one reads the other's value from before that edge. The bench loads two distinct values and then asserts both enables with the cross selects in a single cycle. It passes only if each register holds the other's old value afterwards; a register that picks up an already updated neighbour ends with both registers equal. Subtraction with Y held is also driven back to back with swaps inside full GCD runs, where the flags returned in each cycle decide the next step.

// File: rtl/gcd_dp_pkg.sv
// Package: shared select encodings for the GCD datapath.
// Assumes the controller drives these exact codes on the select inputs.
package gcd_dp_pkg;
    typedef enum logic [1:0] {
        XSRC_OPND = 2'd0,
        XSRC_Y    = 2'd1,
        XSRC_DIFF = 2'd2,
        XSRC_KEEP = 2'd3
    } x_src_e;

    typedef enum logic {
        YSRC_OPND = 1'b0,
        YSRC_X    = 1'b1
    } y_src_e;
endpackage

// File: rtl/gcd_dp_reg.sv
// Module: enable-gated working register with synchronous active-low clear.
// Assumes a single rising-edge clock domain.
module gcd_dp_reg #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    // Capture d on an enabled edge, clear on reset, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (en)
            q <= d;
    end
endmodule

// File: rtl/gcd_dp_alu.sv
// Module: difference and status flags for the GCD datapath.
// Assumes unsigned operands; the difference wraps modulo 2^WIDTH.
module gcd_dp_alu #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] x_val,
    input  logic [WIDTH-1:0] y_val,
    output logic [WIDTH-1:0] diff,
    output logic             lt,
    output logic             zero
);
    // Pure combinational arithmetic and comparison.
    always_comb begin
        diff = x_val - y_val;
        lt   = (x_val < y_val);
        zero = (y_val == '0);
    end
endmodule

// File: rtl/gcd_dp_xmux.sv
// Module: source selector for the X register.
// Assumes the unused code keeps the current X so no undefined value loads.
module gcd_dp_xmux
    import gcd_dp_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  x_src_e           sel,
    input  logic [WIDTH-1:0] opnd,
    input  logic [WIDTH-1:0] y_val,
    input  logic [WIDTH-1:0] diff,
    input  logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] nxt
);
    // Pick the next X from one of four sources.
    always_comb begin
        case (sel)
            XSRC_OPND: nxt = opnd;
            XSRC_Y:    nxt = y_val;
            XSRC_DIFF: nxt = diff;
            default:   nxt = cur;
        endcase
    end
endmodule

// File: rtl/gcd_dp.sv
// Module: iterative GCD datapath top. It holds X and Y, their muxes and the ALU.
// Assumes an external controller drives selects and enables every cycle.
module gcd_dp
    import gcd_dp_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] opnd_x,
    input  logic [WIDTH-1:0] opnd_y,
    input  logic [1:0]       x_sel,
    input  logic             x_en,
    input  logic             y_sel,
    input  logic             y_en,
    output logic             x_lt_y,
    output logic             y_zero,
    output logic [WIDTH-1:0] result
);
    logic [WIDTH-1:0] x_q, y_q, x_d, y_d, diff;
    x_src_e           x_src;
    y_src_e           y_src;

    // Map the raw select ports onto the shared encodings.
    always_comb begin
        x_src = x_src_e'(x_sel);
        y_src = y_src_e'(y_sel);
    end

    gcd_dp_alu #(.WIDTH(WIDTH)) u_alu (
        .x_val(x_q), .y_val(y_q), .diff(diff), .lt(x_lt_y), .zero(y_zero)
    );

    gcd_dp_xmux #(.WIDTH(WIDTH)) u_xmux (
        .sel(x_src), .opnd(opnd_x), .y_val(y_q), .diff(diff), .cur(x_q), .nxt(x_d)
    );

    // Two-way source selector for Y.
    always_comb begin
        y_d = (y_src == YSRC_X) ? x_q : opnd_y;
    end

    gcd_dp_reg #(.WIDTH(WIDTH)) u_xreg (
        .clk(clk), .rst_n(rst_n), .en(x_en), .d(x_d), .q(x_q)
    );

    gcd_dp_reg #(.WIDTH(WIDTH)) u_yreg (
        .clk(clk), .rst_n(rst_n), .en(y_en), .d(y_d), .q(y_q)
    );

    // Result always mirrors the X register.
    always_comb result = x_q;

    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (x_q == '0 && y_q == '0)); // R1
    AST_LOAD_OPND: assert property (@(posedge clk) disable iff (!rst_n)
        (x_en && y_en && x_sel == 2'd0 && y_sel == 1'b0) |=> (x_q == $past(opnd_x) && y_q == $past(opnd_y))); // R2
    AST_SWAP_REGS: assert property (@(posedge clk) disable iff (!rst_n)
        (x_en && y_en && x_sel == 2'd1 && y_sel == 1'b1) |=> (x_q == $past(y_q) && y_q == $past(x_q))); // R3
    AST_SUB_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (x_en && !y_en && x_sel == 2'd2) |=> (x_q == WIDTH'($past(x_q) - $past(y_q)) && $stable(y_q))); // R4
    AST_HOLD_Y: assert property (@(posedge clk) disable iff (!rst_n) !y_en |=> $stable(y_q)); // R5
    AST_KEEP_X: assert property (@(posedge clk) disable iff (!rst_n) (!x_en || x_sel == 2'd3) |=> $stable(x_q)); // R6
    AST_LT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n) x_lt_y |-> !y_zero); // R7
    AST_ZERO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (y_en && y_sel == 1'b0 && opnd_y == '0) |=> y_zero); // R8
endmodule

// File: tb/tb_gcd_dp.sv
// Bench: directed tasks, one per scenario, each checking its own results.
module tb_gcd_dp;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] opnd_x = '0, opnd_y = '0;
    logic [1:0]   x_sel = 2'd3;
    logic         x_en = 1'b0, y_sel = 1'b0, y_en = 1'b0;
    logic         x_lt_y, y_zero;
    logic [W-1:0] result;
    int           n_chk = 0, n_fail = 0;

    gcd_dp #(.WIDTH(W)) dut (
        .clk(clk), .rst_n(rst_n), .opnd_x(opnd_x), .opnd_y(opnd_y),
        .x_sel(x_sel), .x_en(x_en), .y_sel(y_sel), .y_en(y_en),
        .x_lt_y(x_lt_y), .y_zero(y_zero), .result(result)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive controls at a falling edge, let one rising edge pass, land on the next falling edge.
    task automatic step(input logic [1:0] xs, input logic xe, input logic ys, input logic ye);
        x_sel = xs; x_en = xe; y_sel = ys; y_en = ye;
        @(negedge clk);
        x_en = 1'b0; y_en = 1'b0; x_sel = 2'd3;
    endtask

    task automatic load(input logic [W-1:0] a, input logic [W-1:0] b);
        opnd_x = a; opnd_y = b;
        step(2'd0, 1'b1, 1'b0, 1'b1);
    endtask

    // Y is observed by swapping it into X and swapping back.
    task automatic peek_y(output logic [W-1:0] yv);
        step(2'd1, 1'b1, 1'b1, 1'b1);
        yv = result;
        step(2'd1, 1'b1, 1'b1, 1'b1);
    endtask

    task automatic t_reset();
        load(16'h1234, 16'h0056);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 result", result, '0);
        chk("R1 y_zero", {15'd0, y_zero}, 16'd1);
        chk("R1 x_lt_y", {15'd0, x_lt_y}, 16'd0);
    endtask

    task automatic t_load();
        logic [W-1:0] yv;
        load(16'h00A5, 16'h0300);
        chk("R2 x", result, 16'h00A5);
        chk("R9 result follows X", result, 16'h00A5);
        chk("R7 lt", {15'd0, x_lt_y}, 16'd1);
        peek_y(yv);
        chk("R2 y", yv, 16'h0300);
    endtask

    task automatic t_swap();
        logic [W-1:0] yv;
        load(16'h0011, 16'h0999);
        step(2'd1, 1'b1, 1'b1, 1'b1);
        chk("R3 x gets old y", result, 16'h0999);
        chk("R3 flag after swap", {15'd0, x_lt_y}, 16'd0);
        step(2'd3, 1'b0, 1'b0, 1'b0);
        peek_y(yv);
        chk("R3 y gets old x", yv, 16'h0011);
    endtask

    task automatic t_sub();
        logic [W-1:0] yv;
        load(16'd100, 16'd30);
        step(2'd2, 1'b1, 1'b0, 1'b0);
        chk("R4 difference", result, 16'd70);
        peek_y(yv);
        chk("R4 y holds", yv, 16'd30);
        load(16'd5, 16'd7);
        step(2'd2, 1'b1, 1'b0, 1'b0);
        chk("R4 wraps", result, 16'hFFFE);
    endtask

    task automatic t_hold();
        logic [W-1:0] yv;
        load(16'd40, 16'd9);
        opnd_x = 16'hBEEF; opnd_y = 16'hCAFE;
        step(2'd0, 1'b0, 1'b0, 1'b0);
        chk("R5 x held", result, 16'd40);
        step(2'd2, 1'b0, 1'b1, 1'b0);
        chk("R5 x held sub sel", result, 16'd40);
        peek_y(yv);
        chk("R5 y held", yv, 16'd9);
        step(2'd3, 1'b1, 1'b0, 1'b0);
        chk("R6 unused select keeps x", result, 16'd40);
    endtask

    task automatic t_flags();
        load(16'h8000, 16'h7FFF);
        chk("R7 unsigned msb", {15'd0, x_lt_y}, 16'd0);
        load(16'h7FFF, 16'h8000);
        chk("R7 unsigned msb lt", {15'd0, x_lt_y}, 16'd1);
        load(16'd3, 16'd3);
        chk("R7 equal not lt", {15'd0, x_lt_y}, 16'd0);
        chk("R8 nonzero", {15'd0, y_zero}, 16'd0);
        load(16'd3, 16'd0);
        chk("R8 zero", {15'd0, y_zero}, 16'd1);
    endtask

    function automatic logic [W-1:0] ref_gcd(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W-1:0] p = a, q = b, t;
        while (q != 0) begin
            t = p % q; p = q; q = t;
        end
        return p;
    endfunction

    task automatic t_gcd(input logic [W-1:0] a, input logic [W-1:0] b);
        int guard = 0;
        load(a, b);
        while (guard < 20000) begin
            if (x_lt_y) step(2'd1, 1'b1, 1'b1, 1'b1);
            else if (!y_zero) step(2'd2, 1'b1, 1'b0, 1'b0);
            else break;
            guard++;
        end
        chk("R10 gcd", result, ref_gcd(a, b));
    endtask

    initial begin
        #1500000;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk + 1, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        chk("R1 reset result", result, '0);
        rst_n = 1'b1;
        t_load();
        t_swap();
        t_sub();
        t_hold();
        t_flags();
        t_reset();
        t_gcd(16'd48, 16'd18);
        t_gcd(16'd36, 16'd60);
        t_gcd(16'd17, 16'd5);
        t_gcd(16'd0, 16'd7);
        t_gcd(16'd9, 16'd0);
        t_gcd(16'd0, 16'd0);
        t_gcd(16'd1000, 16'd1);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule